// File: doc/BRIEF.md
# Key Wrap Iteration Sequencer

This block runs the block-processing loops of the 64-bit-semiblock key wrap and key unwrap algorithm. Software first fills an internal word store with the R semiblocks and loads the 64-bit A register. It then issues a wrap or unwrap command together with the semiblock count n and a key-size select. The sequencer walks the six rounds over all n semiblocks. For each step it hands a 128-bit block to an external block cipher, waits for the result, and writes the two halves back into A and R[i]. The step counter t is folded into A on the way.

The cipher sits outside the block. It is driven through a start/ready handshake with a decrypt select and a key-size select. The sequencer does not compute the initial A value, pad the message, or check integrity after unwrap. It accepts whatever A and n software supplies, except that n below 2 is refused.

Top module: `kw_iter_seq`

## Requirements
- R1: After reset `ready` is 1, `err` and `done` are 0, `cipher_start` is 0 and `a_rdata` is 0.
- R2: A wrap command runs j = 0..5 outer and i = 1..n inner. Each step presents {A, R[i]} (A in bits 127:64) with `cipher_decrypt` = 0. The result's high half XOR t, with t = n*j + i, becomes A, and its low half becomes R[i].
- R3: An unwrap command runs j = 5 down to 0 and i = n down to 1. Each step presents {A XOR t, R[i]} with `cipher_decrypt` = 1. The result's high half becomes A and its low half becomes R[i]. Unwrap after wrap with the same n and key restores A and the store.
- R4: t is an (N_W+3)-bit count, zero-extended into the low bits of A. A 300-semiblock object reaches t = 1800 and matches the model.
- R5: `key_256` is captured when a command is accepted and drives `cipher_key_256` for the whole operation. Later changes of `key_256` have no effect.
- R6: A command with n = 0 or n = 1 sets `err`, leaves `ready` at 1, makes no cipher call and changes neither A nor the store. The next accepted command clears `err`.
- R7: Wrap or unwrap commands that arrive while `ready` is 0 are ignored.
- R8: Host writes to A (`a_we`) and to the store (`host_we`) are ignored while `ready` is 0.
- R9: `ready` falls in the cycle after a valid command and rises when the last step is written. `done` pulses once in that same cycle. Exactly 6n cipher calls are made.
- R10: `cipher_start` is raised only while `cipher_ready` is 1, and only once per step.
- R11: Semiblock R[i] is held in slot (i-1) mod SLOTS. Word 2*slot holds its high 32 bits and word 2*slot+1 its low 32 bits, so the most significant word comes first. If both commands are raised together, wrap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wrap | input | 1 | Start a wrap run (one-cycle pulse) |
| cmd_unwrap | input | 1 | Start an unwrap run (one-cycle pulse) |
| n_blocks | input | N_W | Semiblock count n, excluding A |
| key_256 | input | 1 | Key-size select, 1 = 256-bit key |
| ready | output | 1 | Idle and able to accept a command |
| err | output | 1 | Last command was refused for n < 2 |
| done | output | 1 | One-cycle pulse when a run completes |
| a_we | input | 1 | Load A from `a_wdata` |
| a_wdata | input | 64 | New A value |
| a_rdata | output | 64 | Current A value |
| host_we | input | 1 | Write one store word |
| host_addr | input | AW | Store word address |
| host_wdata | input | 32 | Store write data |
| host_rdata | output | 32 | Store word at `host_addr` |
| cipher_start | output | 1 | Launch one cipher operation |
| cipher_decrypt | output | 1 | 1 = decipher, 0 = encipher |
| cipher_key_256 | output | 1 | Key-size select for the cipher |
| cipher_block_in | output | 128 | Block presented to the cipher |
| cipher_ready | input | 1 | Cipher idle; result valid |
| cipher_block_out | input | 128 | Cipher result |

## Verification
The bench builds the sequencer with N_W = 14 and SLOTS = 8, so the store holds 16 words. It uses a two-cycle stand-in cipher made of a keyed rotate-and-XOR that can be inverted. The small store lets a 20-semiblock and a 300-semiblock object wrap around the slot index, which puts the modulo placement and counts t beyond 8 bits within reach in a few thousand cycles. The 14-bit count keeps the full t width and the n < 2 refusal at their real sizes.

// File: rtl/kw_pkg.sv
package kw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } kw_state_e;

  // Fold the step count into the low bits of a semiblock.
  function automatic logic [63:0] kw_tweak(input logic [63:0] a, input logic [31:0] t);
    return a ^ {32'b0, t};
  endfunction

  // Step count for round j, semiblock i of n.
  function automatic logic [31:0] kw_step_index(input logic [31:0] n, input logic [2:0] j,
                                                 input logic [31:0] i);
    return n * {29'b0, j} + i;
  endfunction

endpackage

// File: rtl/kw_step_ctr.sv
module kw_step_ctr #(
  parameter int N_W = 14,
  parameter int T_W = N_W + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           load_unwrap,
  input  logic [N_W-1:0] n_in,
  input  logic           adv,
  output logic [2:0]     j,
  output logic [N_W-1:0] i,
  output logic [T_W-1:0] t,
  output logic [N_W-1:0] n_q,
  output logic           dir,
  output logic           last
);

  localparam logic [N_W-1:0] ONE = N_W'(1);

  logic [2:0]     j_q;
  logic [N_W-1:0] i_q;
  logic [T_W-1:0] t_q;
  logic [N_W-1:0] n_r;
  logic           dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q   <= 3'd0;
      i_q   <= '0;
      t_q   <= '0;
      n_r   <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      n_r   <= n_in;
      dir_q <= load_unwrap;
      if (load_unwrap) begin
        j_q <= 3'd5;
        i_q <= n_in;
        t_q <= T_W'(n_in) * T_W'(6);
      end else begin
        j_q <= 3'd0;
        i_q <= ONE;
        t_q <= T_W'(1);
      end
    end else if (adv) begin
      if (!dir_q) begin
        t_q <= t_q + T_W'(1);
        if (i_q == n_r) begin
          i_q <= ONE;
          j_q <= j_q + 3'd1;
        end else begin
          i_q <= i_q + ONE;
        end
      end else begin
        t_q <= t_q - T_W'(1);
        if (i_q == ONE) begin
          i_q <= n_r;
          j_q <= j_q - 3'd1;
        end else begin
          i_q <= i_q - ONE;
        end
      end
    end
  end

  assign j    = j_q;
  assign i    = i_q;
  assign t    = t_q;
  assign n_q  = n_r;
  assign dir  = dir_q;
  assign last = dir_q ? (j_q == 3'd0 && i_q == ONE) : (j_q == 3'd5 && i_q == n_r);

endmodule

// File: rtl/kw_word_store.sv
module kw_word_store #(
  parameter int SLOTS = 64,
  parameter int WORDS = 2 * SLOTS,
  parameter int AW    = $clog2(WORDS),
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [SW-1:0] semi_slot,
  input  logic          semi_we,
  input  logic [63:0]   semi_wdata,
  output logic [63:0]   semi_rdata
);

  logic [WORDS*32-1:0] flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int  SLOT = w / 2;
    localparam bit  LOW  = (w % 2) == 1;
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (semi_we && semi_slot == SW'(SLOT))
        word_q <= LOW ? semi_wdata[31:0] : semi_wdata[63:32];
      else if (host_we && host_addr == AW'(w))
        word_q <= host_wdata;
    end
    assign flat[w*32 +: 32] = word_q;
  end

  assign host_rdata = flat[host_addr*32 +: 32];
  assign semi_rdata = {flat[{semi_slot, 1'b0}*32 +: 32], flat[{semi_slot, 1'b1}*32 +: 32]};

endmodule

// File: rtl/kw_seq_fsm.sv
module kw_seq_fsm
  import kw_pkg::*;
#(
  parameter int N_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wrap,
  input  logic           cmd_unwrap,
  input  logic [N_W-1:0] n_in,
  input  logic           cipher_ready,
  input  logic           last,
  output kw_state_e      state,
  output logic           load,
  output logic           load_unwrap,
  output logic           capture,
  output logic           cipher_start,
  output logic           done,
  output logic           err
);

  kw_state_e state_q, state_d;
  logic      accept, n_ok;

  assign accept       = (state_q == ST_IDLE) && (cmd_wrap || cmd_unwrap);
  assign n_ok         = n_in >= N_W'(2);
  assign load         = accept && n_ok;
  assign load_unwrap  = !cmd_wrap;
  assign capture      = (state_q == ST_WAIT) && cipher_ready;
  assign cipher_start = (state_q == ST_ISSUE) && cipher_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (load) state_d = ST_ISSUE;
      ST_ISSUE: if (cipher_ready) state_d = ST_WAIT;
      ST_WAIT:  if (capture) state_d = last ? ST_IDLE : ST_ISSUE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= capture && last;
      if (accept) err <= !n_ok;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/kw_iter_seq.sv
module kw_iter_seq
  import kw_pkg::*;
#(
  parameter int N_W   = 14,
  parameter int SLOTS = 64,
  localparam int T_W   = N_W + 3,
  localparam int WORDS = 2 * SLOTS,
  localparam int AW    = $clog2(WORDS),
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wrap,
  input  logic           cmd_unwrap,
  input  logic [N_W-1:0] n_blocks,
  input  logic           key_256,
  output logic           ready,
  output logic           err,
  output logic           done,
  input  logic           a_we,
  input  logic [63:0]    a_wdata,
  output logic [63:0]    a_rdata,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata,
  output logic           cipher_start,
  output logic           cipher_decrypt,
  output logic           cipher_key_256,
  output logic [127:0]   cipher_block_in,
  input  logic           cipher_ready,
  input  logic [127:0]   cipher_block_out
);

  kw_state_e      state;
  logic           load, load_unwrap, capture, last;
  logic [2:0]     ctr_j;
  logic [N_W-1:0] ctr_i, ctr_n;
  logic [T_W-1:0] ctr_t;
  logic           ctr_dir;
  logic [SW-1:0]  semi_slot;
  logic [63:0]    semi_rdata;
  logic [63:0]    a_q;
  logic           key_q;

  kw_seq_fsm #(.N_W(N_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wrap     (cmd_wrap),
    .cmd_unwrap   (cmd_unwrap),
    .n_in         (n_blocks),
    .cipher_ready (cipher_ready),
    .last         (last),
    .state        (state),
    .load         (load),
    .load_unwrap  (load_unwrap),
    .capture      (capture),
    .cipher_start (cipher_start),
    .done         (done),
    .err          (err)
  );

  kw_step_ctr #(.N_W(N_W), .T_W(T_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .load_unwrap (load_unwrap),
    .n_in        (n_blocks),
    .adv         (capture),
    .j           (ctr_j),
    .i           (ctr_i),
    .t           (ctr_t),
    .n_q         (ctr_n),
    .dir         (ctr_dir),
    .last        (last)
  );

  assign ready     = (state == ST_IDLE);
  assign semi_slot = SW'(ctr_i - N_W'(1));

  kw_word_store #(.SLOTS(SLOTS)) u_store (
    .clk        (clk),
    .host_we    (host_we && ready),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .semi_slot  (semi_slot),
    .semi_we    (capture),
    .semi_wdata (cipher_block_out[63:0]),
    .semi_rdata (semi_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 64'd0;
      key_q <= 1'b0;
    end else begin
      if (load) key_q <= key_256;
      if (capture)
        a_q <= ctr_dir ? cipher_block_out[127:64]
                       : kw_tweak(cipher_block_out[127:64], 32'(ctr_t));
      else if (a_we && ready)
        a_q <= a_wdata;
    end
  end

  assign a_rdata         = a_q;
  assign cipher_decrypt  = ctr_dir;
  assign cipher_key_256  = key_q;
  assign cipher_block_in = {ctr_dir ? kw_tweak(a_q, 32'(ctr_t)) : a_q, semi_rdata};

endmodule

// File: rtl/kw_iter_seq_chk.sv
module kw_iter_seq_chk
  import kw_pkg::*;
#(
  parameter int N_W = 14,
  parameter int T_W = N_W + 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           err,
  input logic           done,
  input logic           cmd_any,
  input logic [N_W-1:0] n_blocks,
  input logic           cipher_start,
  input logic           cipher_ready,
  input logic           capture,
  input logic           a_we,
  input logic [63:0]    a_q,
  input logic [2:0]     ctr_j,
  input logic [N_W-1:0] ctr_i,
  input logic [N_W-1:0] ctr_n,
  input logic [T_W-1:0] ctr_t
);

  a_r10_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_start |-> (cipher_ready && !ready));

  a_r4_step_matches_index: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (ctr_t == T_W'(kw_step_index(32'(ctr_n), ctr_j, 32'(ctr_i)))));

  a_r6_reject_small_n: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_any && n_blocks < N_W'(2)) |=> (ready && err));

  a_r9_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_any && n_blocks >= N_W'(2)) |=> (!ready && !err));

  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(ctr_n));

  a_r8_a_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !(ready && a_we)) |=> $stable(a_q));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

bind kw_iter_seq kw_iter_seq_chk #(.N_W(N_W), .T_W(T_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .err          (err),
  .done         (done),
  .cmd_any      (cmd_wrap || cmd_unwrap),
  .n_blocks     (n_blocks),
  .cipher_start (cipher_start),
  .cipher_ready (cipher_ready),
  .capture      (capture),
  .a_we         (a_we),
  .a_q          (a_q),
  .ctr_j        (ctr_j),
  .ctr_i        (ctr_i),
  .ctr_n        (ctr_n),
  .ctr_t        (ctr_t)
);

// File: tb/sim_kw_iter_seq.sv
module sim_kw_iter_seq;
  localparam int N_W = 14, SLOTS = 8, WORDS = 16, AW = 4, LAT = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           cmd_wrap = 0, cmd_unwrap = 0, key_256 = 0;
  logic [N_W-1:0] n_blocks = '0;
  logic           ready, err, done;
  logic           a_we = 0;
  logic [63:0]    a_wdata = '0, a_rdata;
  logic           host_we = 0;
  logic [AW-1:0]  host_addr = '0;
  logic [31:0]    host_wdata = '0, host_rdata;
  logic           c_start, c_decrypt, c_key;
  logic [127:0]   c_in;
  logic           c_ready;
  logic [127:0]   c_out;

  kw_iter_seq #(.N_W(N_W), .SLOTS(SLOTS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wrap(cmd_wrap), .cmd_unwrap(cmd_unwrap),
    .n_blocks(n_blocks), .key_256(key_256), .ready(ready), .err(err), .done(done),
    .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cipher_start(c_start), .cipher_decrypt(c_decrypt), .cipher_key_256(c_key),
    .cipher_block_in(c_in), .cipher_ready(c_ready), .cipher_block_out(c_out));

  int checks = 0, fails = 0, calls = 0, dec_calls = 0, viol = 0, dones = 0, cycles = 0;

  function automatic logic [127:0] kmask(input logic k);
    return k ? 128'hA5C3_1F0E_9B72_64D8_0C1A_E37F_5B29_D486 : 128'h3C96_E1D0_7A25_4F8B_C603_19E4_72AD_5F10;
  endfunction
  function automatic logic [127:0] enc_f(input logic [127:0] x, input logic k);
    return {x[122:0], x[127:123]} ^ kmask(k);
  endfunction
  function automatic logic [127:0] dec_f(input logic [127:0] y, input logic k);
    logic [127:0] z;
    z = y ^ kmask(k);
    return {z[4:0], z[127:5]};
  endfunction

  // Stand-in cipher: fixed latency, ready low while working.
  logic [127:0] held;
  logic         h_dec, h_key;
  int           cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_ready <= 1'b1; c_out <= '0; held <= '0; cnt <= 0; h_dec <= 0; h_key <= 0;
    end else if (c_ready) begin
      if (c_start) begin
        held <= c_in; h_dec <= c_decrypt; h_key <= c_key; cnt <= LAT; c_ready <= 1'b0;
        calls <= calls + 1;
        if (c_decrypt) dec_calls <= dec_calls + 1;
      end
    end else if (cnt <= 1) begin
      c_ready <= 1'b1;
      c_out   <= h_dec ? dec_f(held, h_key) : enc_f(held, h_key);
    end else begin
      cnt <= cnt - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) dones <= dones + 1;
    if (c_start && !c_ready) viol <= viol + 1;
  end

  // Reference model state
  logic [63:0] m_a;
  logic [63:0] m_r [SLOTS];

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_wrap(input int n, input logic k);
    for (int j = 0; j <= 5; j++)
      for (int i = 1; i <= n; i++) begin
        logic [127:0] b;
        int s = (i - 1) % SLOTS;
        b = enc_f({m_a, m_r[s]}, k);
        m_a = b[127:64] ^ 64'(n * j + i);
        m_r[s] = b[63:0];
      end
  endtask

  task automatic model_unwrap(input int n, input logic k);
    for (int j = 5; j >= 0; j--)
      for (int i = n; i >= 1; i--) begin
        logic [127:0] b;
        int s = (i - 1) % SLOTS;
        b = dec_f({m_a ^ 64'(n * j + i), m_r[s]}, k);
        m_a = b[127:64];
        m_r[s] = b[63:0];
      end
  endtask

  task automatic host_write(input logic [AW-1:0] ad, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = ad; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  // R11: slot s occupies words 2s (high) and 2s+1 (low).
  task automatic load_data(input int seed);
    for (int s = 0; s < SLOTS; s++) begin
      m_r[s] = 64'h0123_4567_89AB_CDEF * 64'(s + 3 * seed + 1) ^ 64'(seed << 40);
      host_write(AW'(2 * s), m_r[s][63:32]);
      host_write(AW'(2 * s + 1), m_r[s][31:0]);
    end
    m_a = 64'hA6A6_A6A6_A6A6_A6A6 ^ 64'(seed);
    @(negedge clk); a_we = 1; a_wdata = m_a;
    @(negedge clk); a_we = 0;
  endtask

  task automatic check_state(input string req);
    @(negedge clk);
    chk(req, "A register", 128'(a_rdata), 128'(m_a));
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] e;
      host_addr = AW'(w);
      #1;
      e = (w % 2 == 0) ? m_r[w / 2][63:32] : m_r[w / 2][31:0];
      chk(req, $sformatf("store word %0d (R11 order)", w), 128'(host_rdata), 128'(e));
    end
  endtask

  task automatic issue(input logic unw, input int n, input logic k);
    @(negedge clk);
    cmd_wrap = !unw; cmd_unwrap = unw; n_blocks = N_W'(n); key_256 = k;
    @(posedge clk); #1;
    cmd_wrap = 0; cmd_unwrap = 0;
  endtask

  task automatic wait_done(input int d0);
    int lim = 0;
    while (dones == d0 && lim < 40000) begin @(posedge clk); lim++; end
    #1;
    chk("R9", "done seen", 128'(dones > d0), 128'(1));
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "ready", 128'(ready), 128'(1));
    chk("R1", "err", 128'(err), 128'(0));
    chk("R1", "done", 128'(done), 128'(0));
    chk("R1", "cipher_start", 128'(c_start), 128'(0));
    chk("R1", "A", 128'(a_rdata), 128'(0));
  endtask

  task automatic t_wrap(input int n, input logic k, input int seed);
    int c0, d0;
    load_data(seed);
    c0 = calls; d0 = dones;
    issue(0, n, k);
    chk("R9", "ready low after accept", 128'(ready), 128'(0));
    wait_done(d0);
    chk("R9", "ready after done", 128'(ready), 128'(1));
    chk("R9", "cipher calls 6n", 128'(calls - c0), 128'(6 * n));
    chk("R9", "single done pulse", 128'(dones - d0), 128'(1));
    model_wrap(n, k);
    check_state(n > 100 ? "R4" : "R2");
  endtask

  task automatic t_unwrap(input int n, input logic k, input logic [63:0] orig_a);
    int c0, dc0, d0;
    c0 = calls; dc0 = dec_calls; d0 = dones;
    issue(1, n, k);
    wait_done(d0);
    chk("R3", "decrypt calls", 128'(dec_calls - dc0), 128'(6 * n));
    chk("R9", "cipher calls 6n", 128'(calls - c0), 128'(6 * n));
    model_unwrap(n, k);
    chk("R3", "A restored", 128'(m_a), 128'(orig_a));
    check_state("R3");
  endtask

  task automatic t_key256();
    int d0;
    load_data(7);
    d0 = dones;
    issue(0, 3, 1);
    repeat (9) @(negedge clk);
    key_256 = 0;    // R5: change after accept must not matter
    wait_done(d0);
    model_wrap(3, 1);
    check_state("R5");
    d0 = dones;
    issue(1, 3, 1);
    repeat (5) @(negedge clk);
    key_256 = 0;
    wait_done(d0);
    model_unwrap(3, 1);
    chk("R5", "A after 256-bit round trip", 128'(a_rdata), 128'(64'hA6A6_A6A6_A6A6_A6A6 ^ 64'd7));
  endtask

  task automatic t_reject();
    int c0, d0;
    load_data(11);
    c0 = calls; d0 = dones;
    for (int n = 0; n <= 1; n++) begin
      issue(0, n, 0);
      chk("R6", $sformatf("err for n=%0d", n), 128'(err), 128'(1));
      chk("R6", $sformatf("ready for n=%0d", n), 128'(ready), 128'(1));
    end
    issue(1, 1, 0);
    chk("R6", "err for unwrap n=1", 128'(err), 128'(1));
    repeat (8) @(negedge clk);
    chk("R6", "no cipher calls", 128'(calls - c0), 128'(0));
    chk("R6", "no done", 128'(dones - d0), 128'(0));
    check_state("R6");
    issue(0, 2, 0);
    chk("R6", "err cleared by accepted command", 128'(err), 128'(0));
    wait_done(d0);
    model_wrap(2, 0);
    check_state("R6");
  endtask

  task automatic t_busy();
    int c0, d0;
    load_data(23);
    c0 = calls; d0 = dones;
    issue(0, 4, 0);
    repeat (6) @(negedge clk);
    cmd_unwrap = 1; n_blocks = N_W'(2); host_we = 1; host_addr = '0;
    host_wdata = 32'hDEAD_BEEF; a_we = 1; a_wdata = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    cmd_wrap = 1; cmd_unwrap = 0;
    @(negedge clk);
    cmd_wrap = 0; host_we = 0; a_we = 0;
    wait_done(d0);
    chk("R7", "calls unaffected by busy command", 128'(calls - c0), 128'(24));
    chk("R7", "one done only", 128'(dones - d0), 128'(1));
    model_wrap(4, 0);
    check_state("R8");
  endtask

  task automatic t_both_cmds();
    int dc0, d0;
    load_data(31);
    dc0 = dec_calls; d0 = dones;
    @(negedge clk);
    cmd_wrap = 1; cmd_unwrap = 1; n_blocks = N_W'(2); key_256 = 0;
    @(negedge clk);
    cmd_wrap = 0; cmd_unwrap = 0;
    wait_done(d0);
    chk("R11", "wrap wins: no decrypt calls", 128'(dec_calls - dc0), 128'(0));
    model_wrap(2, 0);
    check_state("R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_wrap(2, 0, 1);
    t_unwrap(2, 0, 64'hA6A6_A6A6_A6A6_A6A6 ^ 64'd1);
    t_wrap(5, 0, 2);
    t_unwrap(5, 0, 64'hA6A6_A6A6_A6A6_A6A6 ^ 64'd2);
    t_key256();
    t_reject();
    t_busy();
    t_both_cmds();
    t_wrap(20, 0, 4);
    t_unwrap(20, 0, 64'hA6A6_A6A6_A6A6_A6A6 ^ 64'd4);
    t_wrap(300, 1, 5);
    chk("R10", "start only while cipher ready", 128'(viol), 128'(0));
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule